// File: doc/BRIEF.md
# Dual Wiper Three-Wire Serial Port

This block is the device-side serial port of a two-channel 8-bit digital potentiometer. A host enables the port by raising `ser_en`, then clocks a bit on `ser_din` into a 17-stage shift chain on each rising edge of `ser_clk`. When `ser_en` falls, the chain is copied into the two wiper registers and the stack-select flag. The chain keeps its contents between transfers, so its far end on `ser_dout` always offers the frame stored last. A host that clocks whole bytes therefore reads the stored settings back while it writes new ones.

The 17-bit frame is not a whole number of bytes. A host that moves three bytes, most significant bit first, prefixes the frame with seven padding bits. These pass through the chain and are lost off its far end, so only the final 17 bits count. On read-back the select bit appears first, then wiper 1 and wiper 0, each most significant bit first. After those come the bits the host is sending in the same transfer. Within a frame the select bit is received first, the wiper 1 byte second and the wiper 0 byte last.

All serial inputs pass through a synchroniser into the system clock domain. A controller with five states acts on what they show. `ST_IDLE` is the state while the port is disabled. `ST_ARMED` waits, with the port enabled, for the serial clock to go high. `ST_SHIFT` is a single cycle that moves the chain by one place. `ST_HIGH` waits for the serial clock to go low again. `ST_COMMIT` is a single cycle that loads the wipers.

The transitions are these:
- From `ST_IDLE`, enable high leads to `ST_HIGH` if the serial clock is high, otherwise to `ST_ARMED`.
- From `ST_ARMED`, enable low leads to `ST_COMMIT`; serial clock high leads to `ST_SHIFT`.
- From `ST_SHIFT`, enable low leads to `ST_COMMIT`; serial clock still high leads to `ST_HIGH`, otherwise to `ST_ARMED`.
- From `ST_HIGH`, enable low leads to `ST_COMMIT`; serial clock low leads to `ST_ARMED`.
- From `ST_COMMIT`, enable high leads to `ST_HIGH` or `ST_ARMED` as from `ST_IDLE`, otherwise to `ST_IDLE`.

Top module: `dual_wiper_serial_port`

## Requirements
- R1: A frame is 17 bits. Of the last 17 bits shifted in before commit, the first is the select bit, the next 8 are wiper 1 (most significant bit first) and the last 8 are wiper 0 (most significant bit first).
- R2: Bits shifted in ahead of the last 17 are discarded. A 24-bit write of bytes 01h,0Fh,55h, most significant bit first, stores select=1, wiper1=0Fh, wiper0=55h.
- R3: `ser_dout` always shows the far stage of the chain. A transfer reads out the stored select bit, then wiper 1 and wiper 0 most significant bit first, then the bits that arrived in the same transfer. Repeating each write of 01h,0Fh,55h / 01h,FFh,80h / 01h,80h,80h / 00h,80h,0Fh returns 87h,AAh,80h / FFh,C0h,00h / C0h,40h,00h / 40h,07h,80h.
- R4: The wipers and the select flag change only in the cycle after the port is disabled. While a transfer is in progress they hold their old values.
- R5: A transfer with fewer than 17 clocks still commits whatever the chain holds. From chain {0, 80h, 0Fh}, three clocks carrying 1,1,0 commit select=0, wiper1=00h, wiper0=7Eh.
- R6: Serial clock edges while `ser_en` is low shift nothing. `ser_dout`, the wipers and the chain contents are unchanged.
- R7: Global reset (`rst_n` low) clears the chain, both wipers, the select flag and `ser_dout` to zero.
- R8: `stacked_code` equals wiper 1 when the select flag is 1 and wiper 0 when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Global reset, active low, asynchronous |
| ser_en | input | 1 | Serial port enable, active high; its falling edge commits the frame |
| ser_clk | input | 1 | Serial clock; the data bit is taken on its rising edge |
| ser_din | input | 1 | Serial data in |
| ser_dout | output | 1 | Far stage of the shift chain |
| wiper0_code | output | 8 | Stored wiper 0 setting |
| wiper1_code | output | 8 | Stored wiper 1 setting |
| stack_sel | output | 1 | Stored select flag |
| stacked_code | output | 8 | Wiper setting chosen by the select flag |

## Verification
The assertions rely on every level of `ser_en`, `ser_clk` and `ser_din` lasting several system clock cycles. This lets each serial clock high phase yield exactly one `ST_SHIFT` cycle. They also rely on `ser_en` and `ser_clk` never changing in the same system cycle. The stimulus keeps each serial level for six system cycles between changes. It changes one input at a time, and it sets up `ser_din` a full phase before the rising edge of `ser_clk`.

// File: rtl/dwp_pkg.sv
package dwp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_SHIFT,
        ST_HIGH,
        ST_COMMIT
    } port_state_t;

endpackage

// File: rtl/dwp_sync.sv
module dwp_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    for (genvar g = 0; g < W; g++) begin : g_bit
        logic [STAGES-1:0] pipe;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pipe <= '0;
            end else begin
                pipe <= (pipe << 1) | STAGES'(d[g]);
            end
        end

        assign q[g] = pipe[STAGES-1];
    end

endmodule

// File: rtl/dwp_ctrl.sv
module dwp_ctrl
    import dwp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en_s,
    input  logic        sclk_s,
    output logic        shift_en,
    output logic        commit_en,
    output port_state_t state
);

    port_state_t state_nx;

    // next-state choice
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (en_s) state_nx = sclk_s ? ST_HIGH : ST_ARMED;
            end
            ST_ARMED: begin
                if (!en_s)       state_nx = ST_COMMIT;
                else if (sclk_s) state_nx = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (!en_s)       state_nx = ST_COMMIT;
                else if (sclk_s) state_nx = ST_HIGH;
                else             state_nx = ST_ARMED;
            end
            ST_HIGH: begin
                if (!en_s)        state_nx = ST_COMMIT;
                else if (!sclk_s) state_nx = ST_ARMED;
            end
            ST_COMMIT: begin
                if (en_s) state_nx = sclk_s ? ST_HIGH : ST_ARMED;
                else      state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // outputs
    always_comb begin
        shift_en  = 1'b0;
        commit_en = 1'b0;
        unique case (state)
            ST_SHIFT:  shift_en  = 1'b1;
            ST_COMMIT: commit_en = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/dwp_chain.sv
module dwp_chain #(
    parameter int FRAME_W = 17
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shift_en,
    input  logic               din,
    output logic [FRAME_W-1:0] chain_q
);

    // new bits enter at stage 0 and travel toward the far stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        chain_q <= '0;
        else if (shift_en) chain_q <= {chain_q[FRAME_W-2:0], din};
    end

endmodule

// File: rtl/dwp_wipers.sv
module dwp_wipers #(
    parameter int POT_W   = 8,
    parameter int FRAME_W = 2 * POT_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               commit_en,
    input  logic [FRAME_W-1:0] chain_q,
    output logic [POT_W-1:0]   wiper0_code,
    output logic [POT_W-1:0]   wiper1_code,
    output logic               stack_sel,
    output logic [POT_W-1:0]   stacked_code
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stack_sel   <= 1'b0;
            wiper1_code <= '0;
            wiper0_code <= '0;
        end else if (commit_en) begin
            stack_sel   <= chain_q[FRAME_W-1];
            wiper1_code <= chain_q[2*POT_W-1:POT_W];
            wiper0_code <= chain_q[POT_W-1:0];
        end
    end

    assign stacked_code = stack_sel ? wiper1_code : wiper0_code;

endmodule

// File: rtl/dual_wiper_serial_port.sv
module dual_wiper_serial_port
    import dwp_pkg::*;
#(
    parameter int POT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_en,
    input  logic             ser_clk,
    input  logic             ser_din,
    output logic             ser_dout,
    output logic [POT_W-1:0] wiper0_code,
    output logic [POT_W-1:0] wiper1_code,
    output logic             stack_sel,
    output logic [POT_W-1:0] stacked_code
);

    localparam int FRAME_W = 2 * POT_W + 1;

    logic [2:0]         sync_q;
    logic               en_s;
    logic               sclk_s;
    logic               din_s;
    logic               shift_en;
    logic               commit_en;
    port_state_t        state;
    logic [FRAME_W-1:0] chain_q;

    dwp_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ser_din, ser_clk, ser_en}),
        .q     (sync_q)
    );

    assign en_s   = sync_q[0];
    assign sclk_s = sync_q[1];
    assign din_s  = sync_q[2];

    dwp_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_s      (en_s),
        .sclk_s    (sclk_s),
        .shift_en  (shift_en),
        .commit_en (commit_en),
        .state     (state)
    );

    dwp_chain #(.FRAME_W(FRAME_W)) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .din      (din_s),
        .chain_q  (chain_q)
    );

    assign ser_dout = chain_q[FRAME_W-1];

    dwp_wipers #(.POT_W(POT_W), .FRAME_W(FRAME_W)) u_wipers (
        .clk          (clk),
        .rst_n        (rst_n),
        .commit_en    (commit_en),
        .chain_q      (chain_q),
        .wiper0_code  (wiper0_code),
        .wiper1_code  (wiper1_code),
        .stack_sel    (stack_sel),
        .stacked_code (stacked_code)
    );

endmodule

// File: rtl/dwp_checker.sv
module dwp_checker #(
    parameter int POT_W   = 8,
    parameter int FRAME_W = 2 * POT_W + 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               en_s,
    input logic               shift_en,
    input logic               commit_en,
    input logic               ser_dout,
    input logic [FRAME_W-1:0] chain_q,
    input logic [POT_W-1:0]   wiper0_code,
    input logic [POT_W-1:0]   wiper1_code,
    input logic               stack_sel
);

    AST_SHIFT_TO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> ser_dout == $past(chain_q[FRAME_W-2])); // R3

    AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(ser_dout)); // R6

    AST_WIPER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_en |=> $stable(wiper0_code) && $stable(wiper1_code) && $stable(stack_sel)); // R4

    AST_COMMIT_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        commit_en |=> {stack_sel, wiper1_code, wiper0_code} == $past(chain_q)); // R1

    AST_COMMIT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en_s) |=> commit_en); // R5

    AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({shift_en, commit_en})); // R4

endmodule

bind dual_wiper_serial_port dwp_checker #(.POT_W(POT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_s        (en_s),
    .shift_en    (shift_en),
    .commit_en   (commit_en),
    .ser_dout    (ser_dout),
    .chain_q     (chain_q),
    .wiper0_code (wiper0_code),
    .wiper1_code (wiper1_code),
    .stack_sel   (stack_sel)
);

// File: tb/sim_dual_wiper_serial_port.sv
`timescale 1ns/1ps
module sim_dual_wiper_serial_port;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_en = 1'b0;
    logic       ser_clk = 1'b0;
    logic       ser_din = 1'b0;
    logic       ser_dout;
    logic [7:0] wiper0_code;
    logic [7:0] wiper1_code;
    logic       stack_sel;
    logic [7:0] stacked_code;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    dual_wiper_serial_port u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .ser_en       (ser_en),
        .ser_clk      (ser_clk),
        .ser_din      (ser_din),
        .ser_dout     (ser_dout),
        .wiper0_code  (wiper0_code),
        .wiper1_code  (wiper1_code),
        .stack_sel    (stack_sel),
        .stacked_code (stacked_code)
    );

    // {bytes written, bytes read back when the same write is repeated} (R3)
    localparam logic [47:0] VEC [4] = '{
        {24'h010F55, 24'h87AA80},
        {24'h01FF80, 24'hFFC000},
        {24'h018080, 24'hC04000},
        {24'h00800F, 24'h400780}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic gap();
        repeat (6) @(negedge clk);
    endtask

    // nbits clocks, MSB of wr first; rd collects ser_dout before each rising edge
    task automatic xfer(input logic [23:0] wr, input int nbits, output logic [23:0] rd);
        logic [16:0] held;
        held = {stack_sel, wiper1_code, wiper0_code};
        rd = '0;
        @(negedge clk);
        ser_en = 1'b1;
        gap();
        for (int i = 0; i < nbits; i++) begin
            rd[nbits-1-i] = ser_dout;
            ser_din = wr[nbits-1-i];
            gap();
            ser_clk = 1'b1;
            gap();
            ser_clk = 1'b0;
            gap();
        end
        // R4: nothing committed while still enabled
        chk("R4", {15'd0, stack_sel, wiper1_code, wiper0_code}, {15'd0, held});
        ser_en = 1'b0;
        gap();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [23:0] rd;
        logic        d0;
        repeat (3) @(negedge clk);
        // R7: reset state
        chk("R7", {23'd0, ser_dout}, 32'd0);
        chk("R7", {15'd0, stack_sel, wiper1_code, wiper0_code}, 32'd0);
        rst_n = 1'b1;
        gap();

        foreach (VEC[k]) begin
            xfer(VEC[k][47:24], 24, rd);
            xfer(VEC[k][47:24], 24, rd);
            chk("R3", {8'd0, rd}, {8'd0, VEC[k][23:0]});
            // R1/R2: padding dropped, select from byte0 LSB
            chk("R2", {15'd0, stack_sel, wiper1_code, wiper0_code},
                {15'd0, VEC[k][40], VEC[k][39:32], VEC[k][31:24]});
            chk("R8", {24'd0, stacked_code},
                {24'd0, VEC[k][40] ? VEC[k][39:32] : VEC[k][31:24]});
        end

        // R1: a clean 17-bit frame with no padding
        xfer({7'd0, 1'b1, 8'h3C, 8'hA5}, 17, rd);
        chk("R1", {15'd0, stack_sel, wiper1_code, wiper0_code}, {15'd0, 1'b1, 8'h3C, 8'hA5});
        chk("R8", {24'd0, stacked_code}, 32'h3C);
        xfer(24'h00800F, 24, rd);

        // R5: short transfer of 3 clocks carrying 1,1,0
        xfer(24'h000006, 3, rd);
        chk("R5", {15'd0, stack_sel, wiper1_code, wiper0_code}, {15'd0, 1'b0, 8'h00, 8'h7E});
        chk("R8", {24'd0, stacked_code}, 32'h7E);

        // R6: serial clocks while disabled
        d0 = ser_dout;
        ser_din = 1'b1;
        for (int i = 0; i < 5; i++) begin
            gap();
            ser_clk = 1'b1;
            gap();
            ser_clk = 1'b0;
        end
        gap();
        chk("R6", {31'd0, ser_dout}, {31'd0, d0});
        chk("R6", {15'd0, stack_sel, wiper1_code, wiper0_code}, {15'd0, 1'b0, 8'h00, 8'h7E});
        xfer(24'h000000, 24, rd);
        chk("R6", {8'd0, rd}, 32'h003F00);

        // R7: global reset mid-run
        xfer(24'h01FFFF, 24, rd);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R7", {15'd0, stack_sel, wiper1_code, wiper0_code}, 32'd0);
        chk("R7", {23'd0, ser_dout}, 32'd0);
        rst_n = 1'b1;
        gap();
        xfer(24'h000000, 24, rd);
        chk("R7", {8'd0, rd}, 32'd0);

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule